// File: doc/BRIEF.md
# Serial Flash Command Protection Front-End

This block sits at the pin edge of a serial NOR flash slave and turns an SPI command stream into protected operation requests. It oversamples chip-select, serial clock and data with the system clock. It captures a one-byte opcode, a 24-bit address and any trailing bytes. When chip-select rises, it decides whether a program, erase or status-write command may proceed. It keeps a small status register: the write-enable latch, three block-protect bits and a status-lock bit. A write-protect pin works together with that lock bit.

An accepted command produces a one-cycle request carrying an operation kind and an address for the array model. While the array reports busy, the block honours only status reads. A rejected command disappears without any request. The block also handles a deep power-down state, in which almost every command is ignored, and answers two identification commands.

Top module: `fcp_front`

## Requirements
- R1: Serial data is sampled on rising clock edges and driven on falling clock edges, most significant bit first. This works with the clock idling low (mode 0) or high (mode 3).
- R2: Opcode 05h returns the status byte for as long as clocking continues: bit 0 = busy input, bit 1 = write-enable latch, bits 4:2 = block-protect value, bit 7 = status lock, other bits zero.
- R3: Opcode 06h sets the write-enable latch and opcode 04h clears it.
- R4: Program (02h), sector erase (20h), chip erase (C7h) and status write (01h) produce no request unless the write-enable latch is set.
- R5: A modify command whose clock count at chip-select rise is not a multiple of eight is discarded, and the write-enable latch keeps its value.
- R6: An accepted command raises op_req_o for exactly one cycle, with op_kind_o (0 program, 1 sector erase, 2 chip erase, 3 status write) and op_addr_o. It also clears the write-enable latch. Program needs opcode, 3 address bytes and at least one data byte; sector erase needs opcode and 3 address bytes.
- R7: Block-protect values 0..7 protect the top 0, 1, 2, 4, 8, 16, 32 or 64 of the 64 sectors; the sector is address bits 21:16. Program or sector erase aimed at a protected sector is rejected, and chip erase is rejected while the block-protect value is nonzero.
- R8: Status write (01h plus one data byte) loads block-protect from data bits 4:2 and the status lock from bit 7. It is rejected while the lock is set and wp_ni is low.
- R9: While busy_i is high, every command except the status read has no effect.
- R10: Opcode B9h enters deep power-down (dpd_o high). There, all commands are ignored except ABh, which leaves the state at chip-select rise.
- R11: Opcode ABh followed by three dummy bytes returns the device ID byte (15h) repeatedly. This also works in deep power-down.
- R12: Opcode 90h with three address bytes returns manufacturer ID C2h then device ID 15h, alternating, when address bit 0 is 0. When that bit is 1, the device ID comes first.
- R13: After reset the latch, block-protect, lock and power-down state are clear, miso_o is 0 and no request is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock used for oversampling |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sclk_i | input | 1 | Serial clock from the host |
| cs_ni | input | 1 | Active-low chip-select |
| mosi_i | input | 1 | Serial data from the host |
| wp_ni | input | 1 | Active-low write-protect pin |
| busy_i | input | 1 | Array operation in progress |
| miso_o | output | 1 | Serial data to the host |
| op_req_o | output | 1 | One-cycle operation request |
| op_kind_o | output | 2 | Operation kind of the request |
| op_addr_o | output | 24 | Address of the request |
| dpd_o | output | 1 | Deep power-down state |

## Verification
The bench targets each gate condition on its own. It sends a sector erase that is three bits past a byte boundary, where a design that ignores the clock count would erase anyway. It aims an erase at the lowest protected sector and at the highest unprotected sector, where an off-by-one protection boundary would reject the wrong one. It also tries chip erase with a nonzero protect value. The lock-plus-pin case is checked with the pin both low and high, which catches a design that ignores the pin or locks for good. Power-down is checked by showing that a write-enable sent while asleep left the latch clear. The ID command is read in both address orders and across several bytes, so a design that fails to alternate is caught.

// File: rtl/fcp_pkg.sv
package fcp_pkg;
  localparam logic [7:0] OPC_WREN = 8'h06;
  localparam logic [7:0] OPC_WRDI = 8'h04;
  localparam logic [7:0] OPC_RDSR = 8'h05;
  localparam logic [7:0] OPC_WRSR = 8'h01;
  localparam logic [7:0] OPC_PROG = 8'h02;
  localparam logic [7:0] OPC_SERS = 8'h20;
  localparam logic [7:0] OPC_CERS = 8'hC7;
  localparam logic [7:0] OPC_DPD  = 8'hB9;
  localparam logic [7:0] OPC_WAKE = 8'hAB;
  localparam logic [7:0] OPC_RDID = 8'h90;

  typedef enum logic [1:0] {
    OP_PROG   = 2'd0,
    OP_SERASE = 2'd1,
    OP_CERASE = 2'd2,
    OP_WSTAT  = 2'd3
  } op_kind_e;
endpackage

// File: rtl/fcp_sync.sv
module fcp_sync #(
  parameter int unsigned W = 4,
  parameter logic [W-1:0] RST = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= RST;
      sync_q <= RST;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/fcp_bp_check.sv
module fcp_bp_check #(
  parameter int unsigned NUM_SECTORS = 64,
  localparam int unsigned SECT_W = $clog2(NUM_SECTORS)
) (
  input  logic [2:0]        bp_i,
  input  logic [SECT_W-1:0] sector_i,
  output logic              prot_o
);
  localparam logic [SECT_W:0] NUM = (SECT_W+1)'(NUM_SECTORS);
  logic [SECT_W:0] nprot;

  // top-down region: 0, 1, 2, 4 ... sectors, 7 = whole array
  always_comb begin
    if (bp_i == 3'd0)      nprot = '0;
    else if (bp_i == 3'd7) nprot = NUM;
    else                   nprot = (SECT_W+1)'(1) << (bp_i - 3'd1);
    if (nprot > NUM) nprot = NUM;
  end

  assign prot_o = ({1'b0, sector_i} >= (NUM - nprot));
endmodule

// File: rtl/fcp_front.sv
module fcp_front
  import fcp_pkg::*;
#(
  parameter int unsigned NUM_SECTORS = 64,
  parameter int unsigned SECT_LSB    = 16,
  parameter int unsigned ADDR_W      = 24,
  parameter logic [7:0]  MFR_ID      = 8'hC2,
  parameter logic [7:0]  DEV_ID      = 8'h15
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sclk_i,
  input  logic              cs_ni,
  input  logic              mosi_i,
  input  logic              wp_ni,
  input  logic              busy_i,
  output logic              miso_o,
  output logic              op_req_o,
  output logic [1:0]        op_kind_o,
  output logic [ADDR_W-1:0] op_addr_o,
  output logic              dpd_o
);
  localparam int unsigned SECT_W     = $clog2(NUM_SECTORS);
  localparam int unsigned ADDR_BYTES = ADDR_W / 8;
  localparam logic [2:0]  CNT_MAX    = 3'd7;
  localparam logic [2:0]  ADDR_END   = 3'(ADDR_BYTES + 1);

  logic sclk_s, cs_s, mosi_s, wp_s;
  logic sclk_d, cs_d;

  fcp_sync #(.W(4), .RST(4'b0101)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({sclk_i, cs_ni, mosi_i, wp_ni}),
    .q_o   ({sclk_s, cs_s, mosi_s, wp_s})
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_d <= 1'b0;
      cs_d   <= 1'b1;
    end else begin
      sclk_d <= sclk_s;
      cs_d   <= cs_s;
    end
  end

  logic sck_rise, sck_fall, cs_fall, cs_rise;
  assign sck_rise = sclk_s & ~sclk_d & ~cs_s;
  assign sck_fall = ~sclk_s & sclk_d & ~cs_s;
  assign cs_fall  = ~cs_s & cs_d;
  assign cs_rise  = cs_s & ~cs_d;

  // frame capture
  logic [2:0]        bit_q, byte_q;
  logic              par_q;
  logic [7:0]        sh_q, opc_q, wdat_q;
  logic [ADDR_W-1:0] addr_q;
  logic [7:0]        sh_next;
  assign sh_next = {sh_q[6:0], mosi_s};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_q  <= '0;
      byte_q <= '0;
      par_q  <= 1'b0;
      sh_q   <= '0;
      opc_q  <= '0;
      wdat_q <= '0;
      addr_q <= '0;
    end else if (cs_fall) begin
      bit_q  <= '0;
      byte_q <= '0;
      par_q  <= 1'b0;
      opc_q  <= '0;
    end else if (sck_rise) begin
      sh_q  <= sh_next;
      bit_q <= bit_q + 3'd1;
      if (bit_q == 3'd7) begin
        if (byte_q == 3'd0) opc_q <= sh_next;
        if (byte_q == 3'd1) wdat_q <= sh_next;
        if (byte_q >= 3'd1 && byte_q < ADDR_END)
          addr_q <= {addr_q[ADDR_W-9:0], sh_next};
        if (byte_q != CNT_MAX) byte_q <= byte_q + 3'd1;
        par_q <= ~par_q;
      end
    end
  end

  // status and protection
  logic       wel_q, srwd_q, dpd_q;
  logic [2:0] bp_q;
  logic       prot;
  logic [7:0] stat_byte;
  assign stat_byte = {srwd_q, 2'b00, bp_q, wel_q, busy_i};

  fcp_bp_check #(.NUM_SECTORS(NUM_SECTORS)) u_bp (
    .bp_i    (bp_q),
    .sector_i(addr_q[SECT_LSB +: SECT_W]),
    .prot_o  (prot)
  );

  logic have_op, mod8, exec, gate_ok, accept;
  op_kind_e kind_n;
  assign have_op = (byte_q != 3'd0);
  assign mod8    = (bit_q == 3'd0);
  assign exec    = cs_rise & have_op & ~dpd_q & ~busy_i;

  always_comb begin
    gate_ok = 1'b0;
    kind_n  = OP_PROG;
    unique case (opc_q)
      OPC_PROG: begin kind_n = OP_PROG;   gate_ok = mod8 && byte_q > ADDR_END && !prot; end
      OPC_SERS: begin kind_n = OP_SERASE; gate_ok = mod8 && byte_q >= ADDR_END && !prot; end
      OPC_CERS: begin kind_n = OP_CERASE; gate_ok = mod8 && bp_q == 3'd0; end
      OPC_WRSR: begin kind_n = OP_WSTAT;  gate_ok = mod8 && byte_q >= 3'd2 && !(srwd_q && !wp_s); end
      default:  ;
    endcase
  end
  assign accept = exec & wel_q & gate_ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wel_q     <= 1'b0;
      srwd_q    <= 1'b0;
      bp_q      <= '0;
      dpd_q     <= 1'b0;
      op_req_o  <= 1'b0;
      op_kind_o <= '0;
      op_addr_o <= '0;
    end else begin
      op_req_o <= 1'b0;
      if (cs_rise && have_op && dpd_q && opc_q == OPC_WAKE) dpd_q <= 1'b0;
      if (exec) begin
        if (opc_q == OPC_WREN) wel_q <= 1'b1;
        if (opc_q == OPC_WRDI) wel_q <= 1'b0;
        if (opc_q == OPC_DPD)  dpd_q <= 1'b1;
      end
      if (accept) begin
        wel_q     <= 1'b0;
        op_req_o  <= 1'b1;
        op_kind_o <= kind_n;
        op_addr_o <= (kind_n == OP_PROG || kind_n == OP_SERASE) ? addr_q : '0;
        if (kind_n == OP_WSTAT) begin
          bp_q   <= wdat_q[4:2];
          srwd_q <= wdat_q[7];
        end
      end
    end
  end

  // response path
  logic [7:0] resp;
  logic       miso_q;
  always_comb begin
    resp = '0;
    if (have_op) begin
      unique case (opc_q)
        OPC_RDSR: resp = dpd_q ? 8'h00 : stat_byte;
        OPC_WAKE: resp = (byte_q >= ADDR_END) ? DEV_ID : 8'h00;
        OPC_RDID: if (!dpd_q && byte_q >= ADDR_END)
                    resp = (par_q ^ addr_q[0]) ? DEV_ID : MFR_ID;
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       miso_q <= 1'b0;
    else if (cs_s)     miso_q <= 1'b0;
    else if (sck_fall) miso_q <= resp[3'd7 - bit_q];
  end

  assign miso_o = miso_q;
  assign dpd_o  = dpd_q;

  p_req_needs_wel_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_req_o |-> $past(wel_q));
  p_req_clears_wel_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_req_o |-> !wel_q);
  p_hpm_lock_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (srwd_q && !wp_s) |=> ($stable(bp_q) && srwd_q));
  p_busy_no_req_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(busy_i) |-> !op_req_o);
  p_dpd_no_req_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(dpd_q) |-> !op_req_o);
endmodule

// File: tb/fcp_front_tb.sv
module fcp_front_tb;
  localparam int HALF = 8;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0, wp_n = 1'b1, busy = 1'b0;
  logic miso, op_req, dpd;
  logic [1:0]  op_kind;
  logic [23:0] op_addr;

  always #10 clk = ~clk;

  fcp_front u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .sclk_i(sclk), .cs_ni(cs_n), .mosi_i(mosi),
    .wp_ni(wp_n), .busy_i(busy), .miso_o(miso), .op_req_o(op_req),
    .op_kind_o(op_kind), .op_addr_o(op_addr), .dpd_o(dpd)
  );

  int n_chk = 0, n_err = 0;
  int req_cnt = 0;
  logic [1:0]  last_kind;
  logic [23:0] last_addr;
  logic [7:0]  tx [0:7];
  logic [7:0]  rx [0:7];

  always @(negedge clk) if (op_req) begin
    req_cnt   <= req_cnt + 1;
    last_kind <= op_kind;
    last_addr <= op_addr;
  end

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic xfer(input int nbytes, input int xbits = 0, input bit m3 = 1'b0);
    sclk = m3;
    wclk(4);
    cs_n = 1'b0;
    wclk(HALF);
    for (int b = 0; b < 8; b++) rx[b] = 8'h00;
    for (int k = 0; k < nbytes * 8 + xbits; k++) begin
      sclk = 1'b0;
      mosi = tx[k / 8][7 - (k % 8)];
      wclk(HALF);
      rx[k / 8][7 - (k % 8)] = miso;
      sclk = 1'b1;
      wclk(HALF);
    end
    if (!m3) begin
      sclk = 1'b0;
      wclk(HALF);
    end
    cs_n = 1'b1;
    wclk(2 * HALF);
  endtask

  task automatic cmd(input logic [7:0] b0, input logic [7:0] b1 = 0, input logic [7:0] b2 = 0,
                     input logic [7:0] b3 = 0, input logic [7:0] b4 = 0,
                     input int n = 1, input int xb = 0, input bit m3 = 1'b0);
    for (int i = 0; i < 8; i++) tx[i] = 8'h00;
    tx[0] = b0; tx[1] = b1; tx[2] = b2; tx[3] = b3; tx[4] = b4;
    xfer(n, xb, m3);
  endtask

  task automatic rdsr(input string req, input logic [7:0] exp, input bit m3 = 1'b0);
    cmd(8'h05, .n(3), .m3(m3));
    check(req, rx[1], exp);
    check(req, rx[2], exp);
  endtask

  task automatic t_reset;
    check("R13 miso", miso, 0);
    check("R13 dpd", dpd, 0);
    check("R13 req", req_cnt, 0);
    rdsr("R13 R2 status after reset", 8'h00);
  endtask

  task automatic t_wel;
    cmd(8'h06);
    rdsr("R3 WREN sets latch", 8'h02);
    rdsr("R1 R2 status in mode 3", 8'h02, 1'b1);
    cmd(8'h04);
    rdsr("R3 WRDI clears latch", 8'h00);
  endtask

  task automatic t_no_wel;
    int r0 = req_cnt;
    cmd(8'h20, 8'h00, 8'h00, 8'h00, .n(4));
    check("R4 erase without latch", req_cnt - r0, 0);
  endtask

  task automatic t_pp_ok;
    int r0;
    cmd(8'h06);
    r0 = req_cnt;
    cmd(8'h02, 8'h01, 8'h23, 8'h45, 8'hAA, .n(6), .m3(1'b1));
    check("R6 R1 program request", req_cnt - r0, 1);
    check("R6 program kind", last_kind, 0);
    check("R6 program addr", last_addr, 24'h012345);
    rdsr("R6 latch cleared", 8'h00);
  endtask

  task automatic t_bad_count;
    int r0;
    cmd(8'h06);
    r0 = req_cnt;
    cmd(8'h20, 8'h3F, 8'h00, 8'h00, 8'hFF, .n(4), .xb(3));
    check("R5 unaligned erase dropped", req_cnt - r0, 0);
    rdsr("R5 latch kept", 8'h02);
    cmd(8'h20, 8'h3F, 8'h00, 8'h00, .n(4));
    check("R6 erase request", req_cnt - r0, 1);
    check("R6 erase kind", last_kind, 1);
    check("R6 erase addr", last_addr, 24'h3F0000);
  endtask

  task automatic t_bp;
    int r0;
    cmd(8'h06);
    r0 = req_cnt;
    cmd(8'h01, 8'h08, .n(2));
    check("R8 status write request", req_cnt - r0, 1);
    check("R8 status write kind", last_kind, 3);
    rdsr("R8 bp loaded", 8'h08);
    cmd(8'h06);
    r0 = req_cnt;
    cmd(8'h20, 8'h3E, 8'h00, 8'h00, .n(4));
    check("R7 erase sector 62 protected", req_cnt - r0, 0);
    cmd(8'h20, 8'h3D, 8'h00, 8'h00, .n(4));
    check("R7 erase sector 61 allowed", req_cnt - r0, 1);
    cmd(8'h06);
    r0 = req_cnt;
    cmd(8'hC7);
    check("R7 chip erase blocked", req_cnt - r0, 0);
    rdsr("R7 latch kept after block", 8'h0A);
  endtask

  task automatic t_hpm;
    int r0;
    r0 = req_cnt;
    cmd(8'h01, 8'h9C, .n(2));
    check("R8 lock write accepted", req_cnt - r0, 1);
    rdsr("R8 lock set", 8'h9C);
    wp_n = 1'b0;
    cmd(8'h06);
    r0 = req_cnt;
    cmd(8'h01, 8'h00, .n(2));
    check("R8 locked status write", req_cnt - r0, 0);
    rdsr("R8 status unchanged", 8'h9E);
    cmd(8'h02, 8'h00, 8'h00, 8'h00, 8'h55, .n(5));
    check("R7 program all protected", req_cnt - r0, 0);
    wp_n = 1'b1;
    wclk(4);
    cmd(8'h01, 8'h00, .n(2));
    check("R8 unlock with pin high", req_cnt - r0, 1);
    rdsr("R8 status cleared", 8'h00);
  endtask

  task automatic t_busy;
    busy = 1'b1;
    rdsr("R9 R2 busy bit", 8'h01);
    cmd(8'h06);
    busy = 1'b0;
    wclk(2);
    rdsr("R9 WREN ignored while busy", 8'h00);
  endtask

  task automatic t_ids;
    cmd(8'h90, 8'h00, 8'h00, 8'h00, .n(8));
    check("R12 addr0 byte0", rx[4], 8'hC2);
    check("R12 addr0 byte1", rx[5], 8'h15);
    check("R12 addr0 byte2", rx[6], 8'hC2);
    check("R12 addr0 byte3", rx[7], 8'h15);
    cmd(8'h90, 8'h00, 8'h00, 8'h01, .n(7), .m3(1'b1));
    check("R12 R1 addr1 byte0", rx[4], 8'h15);
    check("R12 addr1 byte1", rx[5], 8'hC2);
    check("R12 addr1 byte2", rx[6], 8'h15);
    cmd(8'hAB, .n(6));
    check("R11 signature", rx[4], 8'h15);
    check("R11 signature repeat", rx[5], 8'h15);
  endtask

  task automatic t_dpd;
    cmd(8'hB9);
    check("R10 enter power-down", dpd, 1);
    cmd(8'h06);
    cmd(8'h90, 8'h00, 8'h00, 8'h00, .n(5));
    check("R10 id ignored asleep", rx[4], 8'h00);
    check("R10 still asleep", dpd, 1);
    cmd(8'hAB, .n(5));
    check("R11 signature asleep", rx[4], 8'h15);
    check("R10 wake", dpd, 0);
    rdsr("R10 WREN ignored asleep", 8'h00);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    wclk(3);
    rst_ni = 1'b1;
    wclk(4);
    t_reset();
    t_wel();
    t_no_wel();
    t_pp_ok();
    t_bad_count();
    t_bp();
    t_hpm();
    t_busy();
    t_ids();
    t_dpd();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule